// File: doc/BRIEF.md
# High-Address Latch and Bank Select Decoder

This block sits between a processor that shares its address pins between the high and low halves of an address and a bank of memory devices. A level-sensitive latch captures seven high-order address bits. While the address strobe is high the latch is transparent. When the strobe falls the latch keeps the value it held at that moment. The five lower latched bits leave the block as the upper address lines of each memory device. The two upper latched bits pick one of four memory banks through four active-low selects. With 8K-byte devices these selects cover a 32K-byte space. With 4K-byte devices the top offset line is simply not connected.

An active-low enable acts on the selects alone. When it is high, every select is forced inactive, whatever the strobe or the address is doing. The enable is applied after the latch, so a change to it takes effect at once, with no strobe needed. If the strobe is tied high, the latch is always transparent. The block then works as a plain pass-through and decoder for a processor whose address bus is not multiplexed.

Top module: `hiaddr_latch_decode`

## Requirements
- R1: While `strobe_i` is high, `mem_addr_o` equals `hi_addr_i[4:0]` in the same cycle.
- R2: After `strobe_i` falls, `mem_addr_o` keeps the value `hi_addr_i[4:0]` had just before the fall. It stays at that value while the strobe is low, however `hi_addr_i` changes.
- R3: With `en_n_i` low and `strobe_i` high, the bank field `hi_addr_i[6:5]` with value k drives `sel_n_o[k]` low. The other three select bits stay high.
- R4: While `en_n_i` is high, `sel_n_o` is 4'b1111, whatever the values of `strobe_i` and `hi_addr_i`.
- R5: With `en_n_i` low and `strobe_i` low, `sel_n_o` decodes the bank field captured at the last strobe fall, not the live input.
- R6: `mem_addr_o` does not depend on `en_n_i`. Toggling the enable leaves the latched address unchanged.
- R7: Driving `en_n_i` low while `strobe_i` stays low brings back the decode of the held bank field at once, with no strobe pulse.
- R8: With `strobe_i` held high, both outputs are pure functions of the current `hi_addr_i` and `en_n_i` for any sequence of inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hi_addr_i | input | 7 | High-order address: bits 4:0 are the offset and bits 6:5 are the bank field |
| strobe_i | input | 1 | Address strobe: high means transparent, the falling edge captures, low means hold |
| en_n_i | input | 1 | Active-low enable for the selects |
| mem_addr_o | output | 5 | Latched upper address lines to the memory devices |
| sel_n_o | output | 4 | Active-low one-of-four bank selects |

## Verification
The block has no clock, so every result is due in the same bench cycle as the stimulus that causes it. No register stage lies between any input and any output. The bench drives inputs just after a rising edge of its own pacing clock and samples both outputs at the following falling edge. By then the latch and the decoder have settled.

A strobe edge and an address change never occur in the same cycle. A strobe fall therefore captures an address that is unambiguous. The expected value can then be tracked by a bench model that updates only while the strobe is high.

// File: rtl/hiaddr_pkg.sv
package hiaddr_pkg;
    // Default geometry: 5 offset bits per device, 2 bank bits -> 4 devices
    localparam int OFFS_W_DEF = 5;
    localparam int BANK_W_DEF = 2;

    // Field order inside the captured word; the decoder depends on bank
    // occupying the top bits.
    typedef struct packed {
        logic [BANK_W_DEF-1:0] bank;
        logic [OFFS_W_DEF-1:0] offs;
    } hiaddr_t;

    // Active-low one-hot for a given bank index, all high when disabled
    function automatic logic [(1<<BANK_W_DEF)-1:0] bank_sel_n(
        input logic [BANK_W_DEF-1:0] bank,
        input logic                  en_n
    );
        logic [(1<<BANK_W_DEF)-1:0] r;
        r = '1;
        if (!en_n) r[bank] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/hiaddr_capture.sv
module hiaddr_capture #(
    parameter int W = 7
) (
    input  logic [W-1:0] d_i,
    input  logic         stb_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] held_q;

    // Transparent while strobe high, holds while low
    always_latch begin
        if (stb_i) held_q = d_i;
    end

    assign q_o = held_q;

    // Transparency: with strobe high the latch content tracks its input
    always_comb begin
        if (stb_i) begin
            assert_transparent_R1: assert (held_q == d_i)
                else $error("latch not transparent while strobe high");
        end
    end
endmodule

// File: rtl/bank_select_decode.sv
module bank_select_decode #(
    parameter int BANK_W = 2,
    localparam int NSEL = 1 << BANK_W
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic              en_n_i,
    output logic [NSEL-1:0]   sel_n_o
);
    // One comparator per select line, each gated by the live enable
    for (genvar k = 0; k < NSEL; k++) begin : g_sel
        assign sel_n_o[k] = en_n_i | (bank_i != BANK_W'(k));
    end

    always_comb begin
        if (en_n_i) begin
            assert_disabled_all_high_R4: assert ($countones(~sel_n_o) == 0)
                else $error("select active while disabled");
        end else begin
            assert_single_low_R3: assert ($countones(~sel_n_o) == 1)
                else $error("enabled select not one-hot low");
        end
    end
endmodule

// File: rtl/hiaddr_latch_decode.sv
module hiaddr_latch_decode #(
    parameter int OFFS_W = hiaddr_pkg::OFFS_W_DEF,
    parameter int BANK_W = hiaddr_pkg::BANK_W_DEF,
    localparam int ADDR_W = OFFS_W + BANK_W,
    localparam int NSEL   = 1 << BANK_W
) (
    input  logic [ADDR_W-1:0] hi_addr_i,
    input  logic              strobe_i,
    input  logic              en_n_i,
    output logic [OFFS_W-1:0] mem_addr_o,
    output logic [NSEL-1:0]   sel_n_o
);
    logic [ADDR_W-1:0] held;
    logic [BANK_W-1:0] held_bank;

    hiaddr_capture #(.W(ADDR_W)) u_capture (
        .d_i   (hi_addr_i),
        .stb_i (strobe_i),
        .q_o   (held)
    );

    // Offset lines bypass the enable entirely
    assign mem_addr_o = held[OFFS_W-1:0];
    assign held_bank  = held[ADDR_W-1:OFFS_W];

    bank_select_decode #(.BANK_W(BANK_W)) u_decode (
        .bank_i  (held_bank),
        .en_n_i  (en_n_i),
        .sel_n_o (sel_n_o)
    );

    // Cross-check between the latch and the decoder: the active line is
    // the one named by the held bank field (R5, R7)
    always_comb begin
        if (!en_n_i) begin
            assert_sel_matches_held_R5: assert (sel_n_o[held_bank] == 1'b0)
                else $error("active select does not match held bank");
        end
    end
endmodule

// File: tb/hiaddr_latch_decode_test.sv
module hiaddr_latch_decode_test;
    logic       clk = 1'b0;
    logic [6:0] hi_addr;
    logic       strobe;
    logic       en_n;
    logic [4:0] mem_addr;
    logic [3:0] sel_n;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    int unsigned cycles = 0;
    logic [6:0]  m_held;   // bench model of captured address

    always #10 clk = ~clk;   // 50 MHz

    hiaddr_latch_decode uut (
        .hi_addr_i  (hi_addr),
        .strobe_i   (strobe),
        .en_n_i     (en_n),
        .mem_addr_o (mem_addr),
        .sel_n_o    (sel_n)
    );

    function automatic logic [3:0] exp_sel(input logic [1:0] bank, input logic dis);
        return dis ? 4'b1111 : ~(4'b0001 << bank);
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // Apply one input set, update model, check at the falling edge
    task automatic apply(input logic [6:0] a, input logic s, input logic e, input string req);
        @(posedge clk);
        hi_addr = a; strobe = s; en_n = e;
        if (s) m_held = a;
        @(negedge clk);
        chk({req, "/addr"}, {3'b0, mem_addr}, {3'b0, m_held[4:0]});
        chk({req, "/sel"},  {4'b0, sel_n},    {4'b0, exp_sel(m_held[6:5], e)});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0] a;
        logic       s, e;
        int unsigned seed = 32'h5EED_0042;
        void'($urandom(seed));
        hi_addr = 7'h00; strobe = 1'b1; en_n = 1'b0; m_held = 7'h00;

        // Initial state after first transparent phase
        apply(7'h00, 1'b1, 1'b0, "R1 init");

        // R3: all four decodes in transparent mode, R1 offset follows
        for (int k = 0; k < 4; k++)
            apply({k[1:0], 5'(7 * k + 3)}, 1'b1, 1'b0, "R3 decode");

        // R2/R5: capture bank 2 offset 0x15, then move address while low
        apply(7'b10_10101, 1'b1, 1'b0, "R1 setup");
        apply(7'b10_10101, 1'b0, 1'b0, "R2 fall");
        apply(7'b01_01010, 1'b0, 1'b0, "R2 hold");
        apply(7'b11_11111, 1'b0, 1'b0, "R5 hold");

        // R4/R6: disable while held, then while transparent
        apply(7'b00_00000, 1'b0, 1'b1, "R4 held");
        apply(7'b00_00000, 1'b0, 1'b1, "R6 held");
        // R7: re-enable without strobe restores bank 2 decode
        apply(7'b01_00001, 1'b0, 1'b0, "R7 restore");
        apply(7'b11_01100, 1'b1, 1'b1, "R4 transp");
        apply(7'b01_10011, 1'b1, 1'b1, "R6 transp");
        apply(7'b01_10011, 1'b1, 1'b0, "R3 reenable");

        // R8: strobe tied high, random address and enable
        for (int i = 0; i < 400; i++)
            apply(7'($urandom), 1'b1, 1'($urandom % 4 == 0), "R8 follow");

        // Mixed random: strobe edges never coincide with address changes
        s = 1'b1; a = hi_addr; e = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 == 0) s = ~s;
            else begin
                a = 7'($urandom);
                if ($urandom % 5 == 0) e = ~e;
            end
            apply(a, s, e, s ? "R1 rand" : "R2 rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule